// File: doc/BRIEF.md
# Single-Wire Bus Address Search Controller

This controller finds the 64-bit addresses of every device attached to a shared open-drain single-wire bus. The bus behaves as a wired-AND: while the devices still taking part in the search present a bit, the line reads 0 if any one of them drives 0. The controller walks a binary tree over those responses. Each pass discovers exactly one device, and a short state carried between passes steers the next pass down an unexplored branch.

Every pass starts with a bus reset. When a presence response comes back, the controller sends the search command byte. It then handles each of the 64 address positions the same way: it reads the bit, reads the bit's complement, and writes back the direction it has chosen. Devices whose bit differs from the written direction drop out until the next reset. All bus activity goes through a separate slot engine, reached by a request/acknowledge handshake, so the electrical timing stays outside this block.

Software issues a fresh search with `start_i`, then repeats `next_i` until `last_o` is reported. The address of the device just found appears on `addr_o` when `done_o` rises.

Top module: `addr_search_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `last_o`, `err_o` and `slot_req_o` are 0 and `addr_o` is all zeros.
- R2: Each pass first requests a reset slot (`slot_op_o` = 0). If its returned bit is 0, meaning no presence, the pass ends with `err_o`=1 and `done_o`=1, and no further slot is requested.
- R3: After a presence response, the command byte (default 0xF0) is sent as 8 write slots (`slot_op_o` = 1), least significant bit first, with the bit on `slot_wbit_o`.
- R4: Each address position uses exactly three slots in this order: read (`slot_op_o` = 2), read of the complement, then a write. There are 64 such triads per pass.
- R5: If the bit and its complement both read 1, the pass aborts at once with `err_o`=1 and `done_o`=1, and the search restarts from scratch at the next command.
- R6: If the bit and its complement differ, the direction written is the value of the first read.
- R7: If both reads are 0 (a discrepancy), the direction is chosen by comparing the 1-based position with the last discrepancy of the previous pass. Below it, the previous pass's bit is reused. At it, 1 is taken. Above it, 0 is taken. Whenever 0 is taken at a discrepancy, that position becomes the new last discrepancy. Passes therefore return the devices in ascending order of their bit-reversed address.
- R8: A pass that ends with no 0 taken at any discrepancy sets `last_o`. A `next_i` after that restarts the search from scratch, exactly as `start_i` does.
- R9: `addr_o` bit k holds the direction written in the k-th triad (k = 0 first), so the address is assembled least significant bit first.
- R10: `start_i` and `next_i` are ignored while `busy_o` is 1.
- R11: `slot_req_o` stays high, with `slot_op_o` and `slot_wbit_o` stable, until a cycle with `slot_ack_i`=1 completes the slot.
- R12: `busy_o` rises the cycle after an accepted command. It falls together with the rise of `done_o`, and the two are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a fresh search |
| next_i | input | 1 | Run the next pass of the search |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Pass finished; held until the next command |
| last_o | output | 1 | Finished pass found the final device |
| err_o | output | 1 | Pass aborted (no presence, or no responder) |
| addr_o | output | 64 | Address found by the last pass |
| slot_req_o | output | 1 | Slot request to the slot engine |
| slot_op_o | output | 2 | Slot kind: 0 reset, 1 write, 2 read |
| slot_wbit_o | output | 1 | Bit to write in a write slot |
| slot_ack_i | input | 1 | Slot finished (one-cycle strobe) |
| slot_rbit_i | input | 1 | Sampled bit of a read slot, or presence for a reset slot |

## Verification
The search is run against a wired-AND bus model loaded with device sets of several shapes:
- A single device, where every position answers unambiguously. This isolates the agreement path and the bit order of the assembled address.
- Device pairs that diverge only at the first bit or only at the last bit. These show whether discrepancy bookkeeping works at both ends of the position range.
- Sets of three and four devices with shared prefixes. These force nested discrepancies, where the reuse of earlier bits matters, and they fix a precise enumeration order.

Directed runs cover:
- an empty bus, and a bus with a presence response but no answering device, which separate the two error causes;
- a command pulsed in the middle of a pass;
- a continue request after the final device, which must restart the search.

// File: rtl/srch_pkg.sv
package srch_pkg;

    typedef enum logic [1:0] {
        OP_RST = 2'd0,
        OP_WR  = 2'd1,
        OP_RD  = 2'd2
    } slot_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CMD,
        ST_RDB,
        ST_RDC,
        ST_WR
    } srch_st_t;

endpackage

// File: rtl/srch_dir_pick.sv
module srch_dir_pick #(
    parameter int POS_W = 7
) (
    input  logic             bit_a,
    input  logic             bit_b,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] last_disc,
    input  logic             prev_bit,
    output logic             dir,
    output logic             abort,
    output logic             open_zero
);
    logic split;

    always_comb begin
        split = !bit_a && !bit_b;
        abort = bit_a && bit_b;
        if (!split) begin
            dir = bit_a;
        end else if (pos < last_disc) begin
            dir = prev_bit;
        end else if (pos == last_disc) begin
            dir = 1'b1;
        end else begin
            dir = 1'b0;
        end
        open_zero = split && !dir;
    end
endmodule

// File: rtl/srch_slot_drive.sv
module srch_slot_drive
    import srch_pkg::*;
#(
    parameter int         CMD_W    = 8,
    parameter logic [7:0] CMD_BYTE = 8'hF0,
    localparam int        CI_W     = $clog2(CMD_W)
) (
    input  srch_st_t        st,
    input  logic [CI_W-1:0] cmd_idx,
    input  logic            dir,
    output logic            req,
    output slot_op_t        op,
    output logic            wbit
);
    always_comb begin
        req  = 1'b1;
        op   = OP_RD;
        wbit = 1'b0;
        case (st)
            ST_RST: op = OP_RST;
            ST_CMD: begin
                op   = OP_WR;
                wbit = CMD_BYTE[cmd_idx];
            end
            ST_RDB, ST_RDC: op = OP_RD;
            ST_WR: begin
                op   = OP_WR;
                wbit = dir;
            end
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_search_ctrl.sv
module addr_search_ctrl
    import srch_pkg::*;
#(
    parameter int         ADDR_W   = 64,
    parameter int         CMD_W    = 8,
    parameter logic [7:0] CMD_BYTE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              next_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              last_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              slot_req_o,
    output logic [1:0]        slot_op_o,
    output logic              slot_wbit_o,
    input  logic              slot_ack_i,
    input  logic              slot_rbit_i
);
    localparam int IDX_W = $clog2(ADDR_W);
    localparam int POS_W = $clog2(ADDR_W + 1);
    localparam int CI_W  = $clog2(CMD_W);

    typedef struct packed {
        srch_st_t          st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  last_disc;
        logic [POS_W-1:0]  last_zero;
        logic              id_bit;
        logic              dir;
        logic              busy;
        logic              done;
        logic              last;
        logic              err;
    } regs_t;

    regs_t q, d;

    logic             pick_dir, pick_abort, pick_zero;
    logic [POS_W-1:0] pos;
    slot_op_t         op;

    assign pos = POS_W'(q.idx) + POS_W'(1);

    srch_dir_pick #(.POS_W(POS_W)) u_pick (
        .bit_a     (q.id_bit),
        .bit_b     (slot_rbit_i),
        .pos       (pos),
        .last_disc (q.last_disc),
        .prev_bit  (q.addr[q.idx]),
        .dir       (pick_dir),
        .abort     (pick_abort),
        .open_zero (pick_zero)
    );

    srch_slot_drive #(.CMD_W(CMD_W), .CMD_BYTE(CMD_BYTE)) u_drive (
        .st      (q.st),
        .cmd_idx (q.idx[CI_W-1:0]),
        .dir     (q.dir),
        .req     (slot_req_o),
        .op      (op),
        .wbit    (slot_wbit_o)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i || next_i) begin
                    if (start_i || q.last) begin
                        d.last_disc = '0;
                        d.addr      = '0;
                    end
                    d.last = 1'b0;
                    d.err  = 1'b0;
                    d.done = 1'b0;
                    d.busy = 1'b1;
                    d.st   = ST_RST;
                end
            end
            ST_RST: begin
                if (slot_ack_i) begin
                    if (slot_rbit_i) begin
                        d.idx       = '0;
                        d.last_zero = '0;
                        d.st        = ST_CMD;
                    end else begin
                        d.err       = 1'b1;
                        d.done      = 1'b1;
                        d.busy      = 1'b0;
                        d.last_disc = '0;
                        d.st        = ST_IDLE;
                    end
                end
            end
            ST_CMD: begin
                if (slot_ack_i) begin
                    if (q.idx == IDX_W'(CMD_W - 1)) begin
                        d.idx = '0;
                        d.st  = ST_RDB;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_RDB: begin
                if (slot_ack_i) begin
                    d.id_bit = slot_rbit_i;
                    d.st     = ST_RDC;
                end
            end
            ST_RDC: begin
                if (slot_ack_i) begin
                    if (pick_abort) begin
                        d.err       = 1'b1;
                        d.done      = 1'b1;
                        d.busy      = 1'b0;
                        d.last_disc = '0;
                        d.st        = ST_IDLE;
                    end else begin
                        d.dir = pick_dir;
                        if (pick_zero) begin
                            d.last_zero = pos;
                        end
                        d.st = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (slot_ack_i) begin
                    d.addr[q.idx] = q.dir;
                    if (q.idx == IDX_W'(ADDR_W - 1)) begin
                        d.last_disc = q.last_zero;
                        d.last      = (q.last_zero == '0);
                        d.done      = 1'b1;
                        d.busy      = 1'b0;
                        d.st        = ST_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_RDB;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign last_o    = q.last;
    assign err_o     = q.err;
    assign addr_o    = q.addr;
    assign slot_op_o = op;
endmodule

// File: rtl/srch_chk.sv
module srch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       next_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       last_o,
    input logic       err_o,
    input logic       slot_req_o,
    input logic [1:0] slot_op_o,
    input logic       slot_wbit_o,
    input logic       slot_ack_i
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o && !slot_ack_i |=> slot_req_o && $stable(slot_op_o) && $stable(slot_wbit_o));

    // R12
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R1
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !slot_req_o);

    // R12
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10
    cmd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && slot_req_o && !slot_ack_i && (start_i || next_i) |=> busy_o);

    // R8
    last_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> !err_o && done_o);
endmodule

bind addr_search_ctrl srch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .next_i      (next_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .last_o      (last_o),
    .err_o       (err_o),
    .slot_req_o  (slot_req_o),
    .slot_op_o   (slot_op_o),
    .slot_wbit_o (slot_wbit_o),
    .slot_ack_i  (slot_ack_i)
);

// File: tb/addr_search_ctrl_tb.sv
module addr_search_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        next_i = 1'b0;
    logic        busy_o, done_o, last_o, err_o;
    logic [63:0] addr_o;
    logic        slot_req_o, slot_wbit_o;
    logic [1:0]  slot_op_o;
    logic        slot_ack_i = 1'b0;
    logic        slot_rbit_i = 1'b0;

    always #5 clk = ~clk;

    addr_search_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_i(next_i),
        .busy_o(busy_o), .done_o(done_o), .last_o(last_o), .err_o(err_o),
        .addr_o(addr_o), .slot_req_o(slot_req_o), .slot_op_o(slot_op_o),
        .slot_wbit_o(slot_wbit_o), .slot_ack_i(slot_ack_i), .slot_rbit_i(slot_rbit_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    // stimulus table: device sets, four entries each, count in SC_CNT
    localparam int NSC = 5;
    localparam int SC_CNT [NSC] = '{1, 2, 2, 4, 3};
    localparam logic [63:0] SC_DEV [NSC*4] = '{
        64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0, 64'h0,
        64'h0F0F_0000_1111_2222, 64'h8F0F_0000_1111_2222, 64'h0, 64'h0,
        64'hA5A5_A5A5_A5A5_A5A4, 64'hA5A5_A5A5_A5A5_A5A5, 64'h0, 64'h0,
        64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002,
        64'hFFFF_0000_0000_0003, 64'h8000_0000_0000_0000,
        64'hCAFE_0000_0000_00F1, 64'hCAFE_0000_0000_00F3, 64'h4AFE_0000_0000_00F1, 64'h0
    };

    // wired-AND bus model
    logic [63:0] dev [4];
    int          ndev = 0;
    bit          ghost = 1'b0;
    logic [3:0]  active;
    int          cmd_cnt, bitpos, step, nslot, dly;
    logic [7:0]  cmd_rx;
    bit          proto_err;
    logic        acc;

    always @(posedge clk) begin
        if (slot_ack_i) begin
            slot_ack_i <= 1'b0;
        end else if (slot_req_o) begin
            if (dly < 1) begin
                dly = dly + 1;
            end else begin
                dly = 0;
                nslot = nslot + 1;
                slot_ack_i <= 1'b1;
                case (slot_op_o)
                    2'd0: begin
                        active = '0;
                        for (int i = 0; i < ndev; i++) active[i] = 1'b1;
                        cmd_cnt = 0; bitpos = 0; step = 0;
                        slot_rbit_i <= (ndev > 0) || ghost;
                    end
                    2'd1: begin
                        if (cmd_cnt < 8) begin
                            cmd_rx[cmd_cnt] = slot_wbit_o;
                            cmd_cnt = cmd_cnt + 1;
                        end else begin
                            if (step != 2) proto_err = 1'b1;
                            for (int i = 0; i < 4; i++)
                                if (active[i] && dev[i][bitpos] != slot_wbit_o) active[i] = 1'b0;
                            bitpos = bitpos + 1;
                            step = 0;
                        end
                    end
                    default: begin
                        if (cmd_cnt < 8 || step > 1) proto_err = 1'b1;
                        acc = 1'b1;
                        for (int i = 0; i < 4; i++)
                            if (active[i] && bitpos < 64)
                                acc = acc & (step == 0 ? dev[i][bitpos] : ~dev[i][bitpos]);
                        slot_rbit_i <= acc;
                        step = step + 1;
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input bit fresh);
        @(negedge clk);
        nslot = 0; proto_err = 1'b0; cmd_rx = '0; bitpos = 0;
        if (fresh) start_i = 1'b1; else next_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; next_i = 1'b0;
        chk(busy_o && !done_o, "R12", "busy after command", {62'd0, busy_o, done_o}, 64'd2);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    function automatic logic [63:0] brev(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    task automatic load(input int sc);
        ndev = SC_CNT[sc];
        ghost = 1'b0;
        for (int i = 0; i < 4; i++) dev[i] = SC_DEV[sc*4+i];
    endtask

    task automatic run_scenario(input int sc);
        bit [3:0] found;
        int best;
        found = '0;
        load(sc);
        for (int p = 0; p < SC_CNT[sc]; p++) begin
            pulse(p == 0);
            wait_done();
            best = -1;
            for (int i = 0; i < ndev; i++)
                if (!found[i] && (best < 0 || brev(dev[i]) < brev(dev[best]))) best = i;
            found[best] = 1'b1;
            chk(addr_o == dev[best], "R7", "enumeration order / address", addr_o, dev[best]);
            chk(last_o == (p == SC_CNT[sc] - 1), "R8", "last flag", {63'd0, last_o},
                {63'd0, (p == SC_CNT[sc] - 1)});
            chk(!err_o, "R6", "no error on populated bus", {63'd0, err_o}, 64'd0);
            chk(cmd_rx == 8'hF0, "R3", "command byte", {56'd0, cmd_rx}, 64'hF0);
            chk(!proto_err && bitpos == 64, "R4", "triad order and count",
                {32'd0, bitpos}, 64'd64);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        dly = 0; nslot = 0; proto_err = 1'b0; active = '0; cmd_cnt = 0; step = 0; bitpos = 0;
        cmd_rx = '0;
        for (int i = 0; i < 4; i++) dev[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !last_o && !err_o && !slot_req_o && addr_o == 0,
            "R1", "reset state", {59'd0, busy_o, done_o, last_o, err_o, slot_req_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!slot_req_o, "R1", "no request after reset", {63'd0, slot_req_o}, 64'd0);

        // main table
        for (int sc = 0; sc < NSC; sc++) run_scenario(sc);

        // R9 single device, asymmetric address: bit order LSB first
        load(0);
        pulse(1'b1); wait_done();
        chk(addr_o[3:0] == 4'h0 && addr_o[63:60] == 4'h1, "R9", "LSB-first assembly",
            addr_o, 64'h1234_5678_9ABC_DEF0);

        // R2 empty bus: no presence
        ndev = 0; ghost = 1'b0;
        pulse(1'b1); wait_done();
        chk(err_o && done_o && !busy_o, "R2", "no presence error", {63'd0, err_o}, 64'd1);
        repeat (6) @(negedge clk);
        chk(nslot == 1, "R2", "no slot after failed reset", {32'd0, nslot}, 64'd1);

        // R5 presence but nobody answers
        ghost = 1'b1;
        pulse(1'b1); wait_done();
        chk(err_o && !last_o, "R5", "both ones abort", {63'd0, err_o}, 64'd1);
        chk(bitpos == 0 && step == 2, "R5", "aborted at first position", {32'd0, bitpos}, 64'd0);

        // R10 command mid-pass ignored; R8 next after last restarts
        load(1);
        pulse(1'b1); wait_done();
        chk(!err_o && addr_o == dev[0], "R5", "search usable after error", addr_o, dev[0]);
        pulse(1'b0);
        repeat (100) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R10", "still busy after mid-pass start", {63'd0, busy_o}, 64'd1);
        wait_done();
        chk(addr_o == dev[1] && last_o, "R10", "pass continued, second device", addr_o, dev[1]);
        pulse(1'b0); wait_done();
        chk(addr_o == dev[0] && !last_o, "R8", "next after last restarts", addr_o, dev[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule